// File: doc/BRIEF.md
# Source Match Result Encoder

This block condenses the outcome of source-address matching for one received frame into a 7-bit result index and a one-cycle valid pulse. Its inputs are a 24-bit match mask with one bit per table entry, a type flag that tells whether the frame carried a short or an extended source address, and two 24-bit pending-enable masks. The short mask has one bit per entry. The extended mask covers 12 entries, one on each even bit.

When `res_stb` is high at a rising clock edge, the encoder registers three things:
- the position of the lowest set bit of the match mask;
- a type bit;
- an auto-pending bit, taken from the enable mask that belongs to the frame's address type.

When no mask bit is set, the encoder registers the no-match code 0x3F instead. The index then holds until the next strobe.

The output has no back-pressure. `res_stb` acts as an input valid that the block always accepts, and `idx_vld` is a one-cycle pulse that the consumer must capture when it appears. Both interfaces are control pins, so the block has no ready signal.

Top module: `srcmatch_result_enc`

## Requirements
- R1: While `rst` is high at a rising edge, `idx_out` becomes 0x3F and `idx_vld` becomes 0 on that edge.
- R2: `idx_vld` is 1 for exactly the one cycle after each edge that samples `res_stb` high, and 0 after an edge that samples it low.
- R3: On a match, `idx_out[4:0]` holds the bit position of the lowest set bit of `match_mask`.
- R4: When `match_mask` is zero at the strobe, `idx_out` becomes 0x3F (bit 6 clear), and `idx_vld` still pulses.
- R5: On a match, `idx_out[5]` is 0 when `is_ext` was 0 (short address) and 1 when `is_ext` was 1 (extended address).
- R6: On a short match at position p, `idx_out[6]` equals `short_pend_en[p]`.
- R7: On an extended match at position p, the entry number is p/2 (rounded down) and `idx_out[6]` equals `ext_pend_en[2*(p/2)]`. The odd bits of `ext_pend_en` have no effect.
- R8: `idx_out` keeps its value between strobes. A change of any input after the strobe edge does not alter the registered result.
- R9: When several bits of `match_mask` are set, only the lowest one decides the index and the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_stb | input | 1 | Result strobe; inputs are sampled on the edge where it is high |
| match_mask | input | 24 | One bit per table entry that matched |
| is_ext | input | 1 | 0: short source address, 1: extended source address |
| short_pend_en | input | 24 | Auto-pending enable, one bit per short entry |
| ext_pend_en | input | 24 | Auto-pending enable; extended entry n uses bit 2n |
| idx_out | output | 7 | Registered result index {pend, type, position} or 0x3F |
| idx_vld | output | 1 | One-cycle pulse marking a new index |

## Verification
A wrong priority decision or a wrong mask bit selection shows at `idx_out` on the first edge after the strobe. Because the index is held, the bad value then stays visible until the next strobe. A stuck or stretched valid register shows as `idx_vld` being wrong in the cycle right after a strobe, or in the cycle after that. A register that updates when it should hold shows when the inputs are changed between strobes. The bench therefore checks the held index again after disturbing the inputs.

// File: rtl/srcm_pkg.sv
package srcm_pkg;
  localparam int POS_W   = 5;
  localparam int IDX_W   = 7;
  localparam logic [IDX_W-1:0] NOMATCH_CODE = 7'h3F;
  localparam int TYPE_BIT = 5;
  localparam int PEND_BIT = 6;

  typedef struct packed {
    logic             pend;
    logic             is_ext;
    logic [POS_W-1:0] pos;
  } srcm_idx_t;
endpackage

// File: rtl/srcm_lsb_find.sv
module srcm_lsb_find #(
  parameter int W     = 24,
  parameter int GRP   = 8,
  parameter int POS_W = 5
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int NG    = (W + GRP - 1) / GRP;
  localparam int PADW  = NG * GRP;
  localparam int LOC_W = (GRP > 1) ? $clog2(GRP) : 1;

  logic [PADW-1:0]           padded;
  logic [NG-1:0]             grp_any;
  logic [NG-1:0][LOC_W-1:0]  grp_pos;

  assign padded = PADW'(vec_i);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [LOC_W-1:0] loc;
    always_comb begin
      loc = '0;
      for (int b = GRP - 1; b >= 0; b--) begin
        if (padded[g*GRP + b]) loc = LOC_W'(b);
      end
    end
    assign grp_any[g] = |padded[g*GRP +: GRP];
    assign grp_pos[g] = loc;
  end

  always_comb begin
    pos_o = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_any[g]) pos_o = POS_W'(g * GRP + int'(grp_pos[g]));
    end
  end

  assign found_o = |grp_any;

  // R3: the reported position is a set bit; R9: no lower bit is set
  always_comb begin
    if (found_o) begin
      a_r3_hit_is_set: assert (vec_i[pos_o]);
      a_r9_nothing_below: assert ((vec_i & ((W'(1) << pos_o) - W'(1))) == '0);
    end
  end
endmodule

// File: rtl/srcm_pend_sel.sv
module srcm_pend_sel #(
  parameter int W     = 24,
  parameter int POS_W = 5
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             is_ext_i,
  input  logic [W-1:0]     short_en_i,
  input  logic [W-1:0]     ext_en_i,
  output logic             pend_o
);
  logic [POS_W-1:0] even_pos;
  logic             in_range;

  // extended entry n = pos/2, enabled by bit 2n
  assign even_pos = {pos_i[POS_W-1:1], 1'b0};
  assign in_range = int'(pos_i) < W;

  always_comb begin
    pend_o = 1'b0;
    if (in_range) begin
      if (is_ext_i) pend_o = ext_en_i[even_pos];
      else          pend_o = short_en_i[pos_i];
    end
  end
endmodule

// File: rtl/srcm_result_reg.sv
module srcm_result_reg
  import srcm_pkg::*;
#(
  parameter int PW = POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic             found_i,
  input  logic [PW-1:0]    pos_i,
  input  logic             is_ext_i,
  input  logic             pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  srcm_idx_t nxt;

  always_comb begin
    nxt.pend   = pend_i;
    nxt.is_ext = is_ext_i;
    nxt.pos    = POS_W'(pos_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= NOMATCH_CODE;
      vld_o <= 1'b0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) idx_o <= found_i ? IDX_W'(nxt) : NOMATCH_CODE;
    end
  end
endmodule

// File: rtl/srcmatch_result_enc.sv
module srcmatch_result_enc
  import srcm_pkg::*;
#(
  parameter int MASK_W = 24,
  parameter int GRP    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_stb,
  input  logic [MASK_W-1:0] match_mask,
  input  logic              is_ext,
  input  logic [MASK_W-1:0] short_pend_en,
  input  logic [MASK_W-1:0] ext_pend_en,
  output logic [IDX_W-1:0]  idx_out,
  output logic              idx_vld
);
  logic             found;
  logic [POS_W-1:0] pos;
  logic             pend;

  srcm_lsb_find #(.W(MASK_W), .GRP(GRP), .POS_W(POS_W)) u_find (
    .vec_i   (match_mask),
    .found_o (found),
    .pos_o   (pos)
  );

  srcm_pend_sel #(.W(MASK_W), .POS_W(POS_W)) u_pend (
    .pos_i      (pos),
    .is_ext_i   (is_ext),
    .short_en_i (short_pend_en),
    .ext_en_i   (ext_pend_en),
    .pend_o     (pend)
  );

  srcm_result_reg #(.PW(POS_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .stb_i    (res_stb),
    .found_i  (found),
    .pos_i    (pos),
    .is_ext_i (is_ext),
    .pend_i   (pend),
    .idx_o    (idx_out),
    .vld_o    (idx_vld)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (idx_out == NOMATCH_CODE) && !idx_vld);

  a_r2_pulse_on: assert property (@(posedge clk) disable iff (rst)
    res_stb |=> idx_vld);

  a_r2_pulse_off: assert property (@(posedge clk) disable iff (rst)
    !res_stb |=> !idx_vld);

  a_r4_nomatch_code: assert property (@(posedge clk) disable iff (rst)
    (res_stb && (match_mask == '0)) |=> (idx_out == NOMATCH_CODE));

  a_r5_type_bit: assert property (@(posedge clk) disable iff (rst)
    (res_stb && (match_mask != '0)) |=> (idx_out[TYPE_BIT] == $past(is_ext)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !res_stb |=> $stable(idx_out));
endmodule

// File: tb/test_srcmatch_result_enc.sv
module test_srcmatch_result_enc;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         res_stb = 1'b0;
  logic [W-1:0] match_mask = '0;
  logic         is_ext = 1'b0;
  logic [W-1:0] short_pend_en = '0;
  logic [W-1:0] ext_pend_en = '0;
  logic [6:0]   idx_out;
  logic         idx_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srcmatch_result_enc i_srcmatch_result_enc (
    .clk(clk), .rst(rst), .res_stb(res_stb), .match_mask(match_mask),
    .is_ext(is_ext), .short_pend_en(short_pend_en), .ext_pend_en(ext_pend_en),
    .idx_out(idx_out), .idx_vld(idx_vld)
  );

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] model(logic [W-1:0] m, logic e,
                                       logic [W-1:0] se, logic [W-1:0] ee);
    for (int p = 0; p < W; p++) begin
      if (m[p]) begin
        logic pd;
        pd = e ? ee[2*(p/2)] : se[p];
        return {pd, e, 5'(p)};
      end
    end
    return 7'h3F;
  endfunction

  // strobe one result; check the pulse and index, then the pulse falling
  task automatic strobe(string req, logic [W-1:0] m, logic e,
                        logic [W-1:0] se, logic [W-1:0] ee);
    logic [6:0] exp;
    exp = model(m, e, se, ee);
    @(negedge clk);
    match_mask = m; is_ext = e; short_pend_en = se; ext_pend_en = ee;
    res_stb = 1'b1;
    @(negedge clk);
    res_stb = 1'b0;
    chk({req, " R2 vld high"}, {6'd0, idx_vld}, 7'd1);
    chk(req, idx_out, exp);
    @(negedge clk);
    chk({req, " R2 vld low"}, {6'd0, idx_vld}, 7'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset idx", idx_out, 7'h3F);
    chk("R1 reset vld", {6'd0, idx_vld}, 7'd0);
    rst = 1'b0;
  endtask

  task automatic t_short_positions();
    for (int p = 0; p < W; p++) begin
      strobe("R3 R6 short single", W'(1) << p, 1'b0, 24'hA5C3_96 ^ W'(p), '0);
    end
  endtask

  task automatic t_ext_positions();
    for (int p = 0; p < W; p++) begin
      strobe("R5 R7 ext single", W'(1) << p, 1'b1, '0, 24'h5A_3C69);
    end
  endtask

  task automatic t_nomatch();
    strobe("R4 no match", '0, 1'b1, '1, '1);
    strobe("R4 no match short", '0, 1'b0, '1, '1);
  endtask

  task automatic t_ext_odd_ignored();
    // odd bits set, even bits clear: pending must stay 0
    strobe("R7 odd bits ignored", 24'h000800, 1'b1, '1, 24'hAAAAAA);
    strobe("R7 odd pos uses even bit", 24'h000800, 1'b1, '0, 24'h000400);
  endtask

  task automatic t_priority();
    strobe("R9 lowest wins short", 24'h810010, 1'b0, 24'h800000, '0);
    strobe("R9 lowest wins ext", 24'hC00060, 1'b1, '0, 24'h000040);
    strobe("R9 top bit only", 24'h800000, 1'b0, 24'h800000, '0);
  endtask

  task automatic t_hold();
    logic [6:0] exp;
    exp = model(24'h000100, 1'b0, 24'h000100, '0);
    strobe("R8 setup", 24'h000100, 1'b0, 24'h000100, '0);
    match_mask = 24'h000001; is_ext = 1'b1; short_pend_en = '0; ext_pend_en = '1;
    repeat (3) @(negedge clk);
    chk("R8 held after input change", idx_out, exp);
    chk("R8 no pulse without strobe", {6'd0, idx_vld}, 7'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_short_positions();
    t_ext_positions();
    t_nomatch();
    t_ext_odd_ignored();
    t_priority();
    t_hold();
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule